// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands and returns the 64-bit product, spending one clock cycle per multiplier bit. A single double-width accumulator holds the running partial product in its upper half and the not-yet-consumed multiplier bits in its lower half. Each cycle the least significant bit of the accumulator decides whether the multiplicand is added into the upper half. The whole accumulator then moves one place to the right, so the multiplier is used up in place. Only one adder of operand width is needed.

A client raises `start` for one cycle while the unit is idle. The operands are captured on that edge and `busy` rises. After 32 add-and-shift cycles `busy` falls and `done` pulses for one cycle. At that point the two result halves are valid on `res_hi` and `res_lo`. They stay there until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `res_hi` and `res_lo` are all 0.
- R2: A clock edge with `start`=1 and `busy`=0 captures `mcand_i` and `mplier_i`, and `busy` is 1 in the following cycle.
- R3: `done` is 1 for exactly one cycle. That cycle follows the edge that is 33 edges after the accepting edge, counting the accepting edge as the first. `busy` falls on the same edge as `done` rises.
- R4: When `done` is 1, `res_hi` holds bits 63..32 and `res_lo` holds bits 31..0 of the unsigned product of the captured operands.
- R5: The carry out of the upper-half addition is never lost. For example, 0xFFFFFFFF × 0xFFFFFFFF gives `res_hi`=0xFFFFFFFE and `res_lo`=0x00000001.
- R6: While `busy` is 1, `start` and any change on the operand inputs have no effect on the result or the timing.
- R7: While `busy` is 0 and no start is accepted, `res_hi` and `res_lo` keep their value.
- R8: `busy` and `done` are never 1 in the same cycle. A start offered in the `done` cycle is accepted.
- R9: A zero operand on either side yields a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication, honoured only while idle |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: result valid |
| res_hi | output | 32 | Upper half of the product |
| res_lo | output | 32 | Lower half of the product |

## Verification
A wrong iteration count moves the `done` pulse away from the 33rd edge, which shows at the ports at once. A corrupted accumulator or a dropped carry shows as a wrong `res_hi`/`res_lo` pair in the `done` cycle. Both failures appear within one multiplication. A reference model in the bench compares `busy`, `done` and the held result on every clock, so a lost carry can hide only until the operands exercise it. The all-ones case does that at the first add whose sum overflows.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

    // Operating phase of the sequencer
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Strobes from sequencer to datapath
    typedef struct packed {
        logic load;   // capture operands, clear upper half
        logic step;   // one add-and-shift iteration
    } dp_ctrl_t;

    // Width of an iteration counter able to hold 0..n-1
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sam_seq.sv
module sam_seq
    import shift_add_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output dp_ctrl_t ctrl,
    output logic     busy,
    output logic     done
);
    localparam int CW = cnt_width(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    phase_e        phase;
    logic [CW-1:0] iter;
    logic          accept;

    assign accept    = (phase == PH_IDLE) && start;
    assign ctrl.load = accept;
    assign ctrl.step = (phase == PH_RUN);
    assign busy      = (phase == PH_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_RUN;
                        iter  <= '0;
                    end
                end
                PH_RUN: begin
                    if (iter == LAST) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        iter <= iter + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sam_addshift.sv
module sam_addshift #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   mcand,
    output logic [2*W-1:0] acc_nxt
);
    logic [W:0] upper_sum;

    always_comb begin
        if (acc[0]) begin
            upper_sum = {1'b0, acc[2*W-1:W]} + {1'b0, mcand};
        end else begin
            upper_sum = {1'b0, acc[2*W-1:W]};
        end
        // carry enters the top bit as everything moves right
        acc_nxt = {upper_sum, acc[W-1:1]};
    end
endmodule

// File: rtl/sam_regs.sv
module sam_regs
    import shift_add_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  dp_ctrl_t       ctrl,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    input  logic [2*W-1:0] acc_nxt,
    output logic [2*W-1:0] acc,
    output logic [W-1:0]   mcand
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            mcand <= '0;
        end else if (ctrl.load) begin
            acc   <= {{W{1'b0}}, mplier_i};
            mcand <= mcand_i;
        end else if (ctrl.step) begin
            acc   <= acc_nxt;
        end
    end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import shift_add_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    dp_ctrl_t       ctrl;
    logic [2*W-1:0] acc;
    logic [2*W-1:0] acc_nxt;
    logic [W-1:0]   mcand;

    sam_seq #(.W(W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl),
        .busy  (busy),
        .done  (done)
    );

    sam_addshift #(.W(W)) u_step (
        .acc     (acc),
        .mcand   (mcand),
        .acc_nxt (acc_nxt)
    );

    sam_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .acc_nxt  (acc_nxt),
        .acc      (acc),
        .mcand    (mcand)
    );

    assign res_hi = acc[2*W-1:W];
    assign res_lo = acc[W-1:0];
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] res_lo
);
    localparam int KW = $clog2(W + 2) + 1;

    logic [KW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == KW'(W)));

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(res_hi) && $stable(res_lo)));
endmodule

bind shift_add_mul shift_add_mul_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .res_hi (res_hi),
    .res_lo (res_lo)
);

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] mcand_i = '0;
    logic [W-1:0] mplier_i = '0;
    logic         busy, done;
    logic [W-1:0] res_hi, res_lo;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // reference model state
    logic        m_busy = 1'b0;
    logic        m_done = 1'b0;
    logic [63:0] m_prod = '0;
    int          m_tmr  = 0;

    shift_add_mul #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
    );

    always #5 clk = ~clk;

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural model, advanced on every edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 1'b0; m_done = 1'b0; m_prod = '0; m_tmr = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_tmr++;
                if (m_tmr == W) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                end
            end else if (start) begin
                m_busy = 1'b1;
                m_tmr  = 0;
                m_prod = {32'b0, mcand_i} * {32'b0, mplier_i};
            end
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(busy == m_busy, "R2 busy", 64'(busy), 64'(m_busy));
            check(done == m_done, "R3 done", 64'(done), 64'(m_done));
            check(!(busy && done), "R8 busy/done overlap", 64'({busy, done}), 64'b0);
            if (!m_busy)
                check({res_hi, res_lo} == m_prod, "R7 held result",
                      {res_hi, res_lo}, m_prod);
        end
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input string tag);
        logic [63:0] e;
        int n;
        e = {32'b0, a} * {32'b0, b};
        @(negedge clk);
        mcand_i = a; mplier_i = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == 32, "R3 latency", 64'(n), 64'd32);
        check({res_hi, res_lo} == e, tag, {res_hi, res_lo}, e);
    endtask

    initial begin
        logic [W-1:0] sa, sb;
        logic [63:0]  e;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0, "R1 flags", 64'({busy, done}), 64'b0);
        check({res_hi, res_lo} == 64'b0, "R1 result", {res_hi, res_lo}, 64'b0);
        rst = 1'b0;

        run_mul(32'd8, 32'd9, "R2 small product");
        run_mul(32'h8000_0000, 32'd2, "R4 hi/lo split");
        check(res_hi == 32'd1 && res_lo == 32'd0, "R4 halves",
              {res_hi, res_lo}, 64'h1_0000_0000);
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 carry max");
        check(res_hi == 32'hFFFF_FFFE && res_lo == 32'h1, "R5 carry exact",
              {res_hi, res_lo}, 64'hFFFF_FFFE_0000_0001);
        run_mul(32'd0, 32'hDEAD_BEEF, "R9 zero multiplicand");
        run_mul(32'h1234_5678, 32'd0, "R9 zero multiplier");

        sa = 32'h1357_9BDF; sb = 32'h2468_ACE0;
        for (int k = 0; k < 6; k++) begin
            sa = sa * 32'd1664525 + 32'd1013904223;
            sb = sb * 32'd22695477 + 32'd1;
            run_mul(sa, sb, "R4 pseudo-random product");
        end

        // R6: start and operand changes mid-run are ignored
        e = {32'b0, 32'hCAFE_0001} * {32'b0, 32'h0000_7777};
        @(negedge clk);
        mcand_i = 32'hCAFE_0001; mplier_i = 32'h0000_7777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        mcand_i = 32'hFFFF_FFFF; mplier_i = 32'hFFFF_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == 26, "R6 timing unaffected", 64'(n), 64'd26);
        check({res_hi, res_lo} == e, "R6 result unaffected", {res_hi, res_lo}, e);

        // R8: start offered in the done cycle is accepted
        mcand_i = 32'd3; mplier_i = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 start in done cycle", 64'(busy), 64'd1);
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check({res_hi, res_lo} == 64'd15, "R8 back-to-back result",
              {res_hi, res_lo}, 64'd15);

        // R7: idle hold across many cycles
        repeat (10) @(negedge clk);
        check({res_hi, res_lo} == 64'd15, "R7 hold after idle",
              {res_hi, res_lo}, 64'd15);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule